// File: doc/BRIEF.md
# Redundant-Line Slave Frame Responder

This block is the receive-and-reply core of a slave station on a doubled (redundant) serial field bus. Two line decoders, one on the primary line and one on the standby line, each hand over the words of a received frame together with an end-of-frame mark and a single flag that says the copy decoded cleanly and passed its CRC. The responder waits until both copies are in, or until a bounded skew window has run out. It then takes the primary copy if that copy is good and the standby copy otherwise, and drops the frame when neither is usable.

A master frame is a single 16-bit word. The responder compares the address in that word with a table of logical ports. For a port this station sources, it reads the port's words from an external shared port RAM and streams them to the frame encoder as one contiguous reply. For a port this station sinks, it stores the data of the slave frame that follows into the same RAM. A status request sent to the station's own device address is answered with one status word. All other requests are left unanswered.

Top module: `sfr_responder`

## Requirements
- R1: After reset, no transmit word is presented (tx_valid low) and no RAM access is made (ram_en low).
- R2: Bits 15:12 of a master word hold the function code and bits 11:0 hold the address. Codes 0 to 4 ask a source port for 1, 2, 4, 8 or 16 data words (16 to 256 bits). Reply words are read in order from RAM address port_index*16 + offset, with the offset starting at 0.
- R3: If both copies are good, the primary copy is used. If the primary copy failed decoding or CRC, the standby copy is used.
- R4: If both copies fail, nothing is transmitted and nothing is written to the RAM.
- R5: A request whose address matches no table entry marked as a source, and is not a status request, gets no reply.
- R6: A source port whose data-valid bit is clear is answered with the full requested length, with every word zero.
- R7: Function code 15 sent to the device's own address is answered with exactly one word equal to dev_status. Code 15 sent to any other address gets no reply.
- R8: After a request (code 0 to 4) to a sink port, the next accepted slave frame is written to that port's RAM words in order, starting at offset 0. The write happens only if the slave frame's length equals the requested length. A slave frame with the wrong length, or one that no sink request preceded, is discarded.
- R9: If several table entries hold the same address, the entry with the lowest index is used.
- R10: The second copy may finish up to SKEW_MAX cycles after the first and still be taken into account. If only one copy arrives and it is good, that copy is used.
- R11: A reply is a gap-free run of one word per cycle, with tx_first on its first word and tx_last on its last word.
- R12: Function codes 5 to 14 produce no reply and no RAM write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_vld | input | 1 | Primary line word strobe |
| pri_word | input | WORD_W | Primary line word |
| pri_mst | input | 1 | Primary frame is a master frame (sampled with eof) |
| pri_eof | input | 1 | Last word of primary frame |
| pri_ok | input | 1 | Primary copy decoded and CRC-checked cleanly (sampled with eof) |
| sby_vld | input | 1 | Standby line word strobe |
| sby_word | input | WORD_W | Standby line word |
| sby_mst | input | 1 | Standby frame is a master frame |
| sby_eof | input | 1 | Last word of standby frame |
| sby_ok | input | 1 | Standby copy good |
| dev_addr | input | ADDR_W | Own device address |
| dev_status | input | WORD_W | Word returned for a status request |
| cfg_la | input | NPORT*ADDR_W | Logical address of each port entry |
| cfg_src | input | NPORT | Entry is a source port |
| cfg_snk | input | NPORT | Entry is a sink port |
| cfg_dv | input | NPORT | Source data is valid |
| ram_en | output | 1 | Port RAM access enable |
| ram_we | output | 1 | Port RAM write enable |
| ram_addr | output | RAM_AW | Port RAM word address {port, offset} |
| ram_wdata | output | WORD_W | Port RAM write data |
| ram_rdata | input | WORD_W | Port RAM read data, one cycle after the read |
| tx_valid | output | 1 | Reply word valid |
| tx_first | output | 1 | First word of reply |
| tx_last | output | 1 | Last word of reply |
| tx_data | output | WORD_W | Reply word |

## Verification
The bench builds the block with its defaults: 16-bit words, 12-bit addresses, 16 table entries of up to 16 words each, and an 8-cycle skew window. These values allow every reply length from one word up to the full 16-word port, and they leave room for a table with a duplicated address and for sink, invalid-data and unconfigured entries side by side. With the 8-cycle window, a standby copy delayed by several cycles still lands inside the window. Some scenarios send the two copies with different contents, so the choice of copy can be seen in the reply.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
  typedef enum logic [2:0] {
    ST_WAIT,
    ST_RECV,
    ST_CHECK,
    ST_WRITE,
    ST_READ,
    ST_DRAIN
  } sfr_state_e;

  // where a reply word comes from
  typedef enum logic [1:0] {
    SRC_RAM,
    SRC_ZERO,
    SRC_STAT
  } sfr_src_e;

  localparam logic [3:0] FC_STATUS = 4'd15;
endpackage

// File: rtl/sfr_line_capture.sv
module sfr_line_capture #(
  parameter int WORD_W = 16,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    in_vld,
  input  logic [WORD_W-1:0]       in_word,
  input  logic                    in_mst,
  input  logic                    in_eof,
  input  logic                    in_ok,
  output logic                    done,
  output logic                    good,
  output logic                    is_mst,
  output logic [CNT_W-1:0]        nwords,
  output logic [DEPTH*WORD_W-1:0] words
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic              ovf;
  logic              room;

  assign room = (cnt < CNT_W'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt    <= '0;
      done   <= 1'b0;
      good   <= 1'b0;
      is_mst <= 1'b0;
      ovf    <= 1'b0;
    end else if (in_vld && !done) begin
      if (room) cnt <= cnt + 1'b1;
      else      ovf <= 1'b1;
      if (in_eof) begin
        done   <= 1'b1;
        good   <= in_ok && !ovf && room;
        is_mst <= in_mst;
      end
    end
  end

  // data storage kept free of reset
  always_ff @(posedge clk) begin
    if (in_vld && !done && room) mem[cnt[IDX_W-1:0]] <= in_word;
  end

  assign nwords = cnt;

  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    assign words[g*WORD_W +: WORD_W] = mem[g];
  end
endmodule

// File: rtl/sfr_port_match.sv
module sfr_port_match #(
  parameter int NPORT  = 16,
  parameter int ADDR_W = 12,
  localparam int PIDX_W = $clog2(NPORT)
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic [NPORT*ADDR_W-1:0] cfg_la,
  input  logic [NPORT-1:0]        cfg_src,
  input  logic [NPORT-1:0]        cfg_snk,
  input  logic [NPORT-1:0]        cfg_dv,
  output logic                    hit,
  output logic [PIDX_W-1:0]       idx,
  output logic                    is_src,
  output logic                    is_snk,
  output logic                    dvalid
);
  logic [NPORT-1:0] match;

  for (genvar g = 0; g < NPORT; g++) begin : g_cmp
    assign match[g] = (cfg_la[g*ADDR_W +: ADDR_W] == addr) && (cfg_src[g] || cfg_snk[g]);
  end

  // lowest matching index wins
  always_comb begin
    idx = '0;
    for (int i = NPORT - 1; i >= 0; i--) begin
      if (match[i]) idx = PIDX_W'(i);
    end
  end

  assign hit    = |match;
  assign is_src = hit && cfg_src[idx];
  assign is_snk = hit && cfg_snk[idx];
  assign dvalid = cfg_dv[idx];
endmodule

// File: rtl/sfr_responder.sv
module sfr_responder
  import sfr_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int ADDR_W     = 12,
  parameter int FC_W       = 4,
  parameter int NPORT      = 16,
  parameter int PORT_WORDS = 16,
  parameter int SKEW_MAX   = 8,
  localparam int PIDX_W    = $clog2(NPORT),
  localparam int OFF_W     = $clog2(PORT_WORDS),
  localparam int RAM_AW    = PIDX_W + OFF_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pri_vld,
  input  logic [WORD_W-1:0]       pri_word,
  input  logic                    pri_mst,
  input  logic                    pri_eof,
  input  logic                    pri_ok,
  input  logic                    sby_vld,
  input  logic [WORD_W-1:0]       sby_word,
  input  logic                    sby_mst,
  input  logic                    sby_eof,
  input  logic                    sby_ok,
  input  logic [ADDR_W-1:0]       dev_addr,
  input  logic [WORD_W-1:0]       dev_status,
  input  logic [NPORT*ADDR_W-1:0] cfg_la,
  input  logic [NPORT-1:0]        cfg_src,
  input  logic [NPORT-1:0]        cfg_snk,
  input  logic [NPORT-1:0]        cfg_dv,
  output logic                    ram_en,
  output logic                    ram_we,
  output logic [RAM_AW-1:0]       ram_addr,
  output logic [WORD_W-1:0]       ram_wdata,
  input  logic [WORD_W-1:0]       ram_rdata,
  output logic                    tx_valid,
  output logic                    tx_first,
  output logic                    tx_last,
  output logic [WORD_W-1:0]       tx_data
);
  localparam int CNT_W  = $clog2(PORT_WORDS + 1);
  localparam int MAX_FC = OFF_W;
  localparam int SKW_W  = $clog2(SKEW_MAX + 1);

  // ---------------- line capture, index 0 primary, 1 standby
  logic [1:0]                   ln_vld, ln_mst, ln_eof, ln_ok;
  logic [WORD_W-1:0]            ln_word [2];
  logic [1:0]                   cap_done, cap_good, cap_mst;
  logic [CNT_W-1:0]             cap_n   [2];
  logic [PORT_WORDS*WORD_W-1:0] cap_buf [2];
  logic                         clr_q;

  assign ln_vld     = {sby_vld, pri_vld};
  assign ln_mst     = {sby_mst, pri_mst};
  assign ln_eof     = {sby_eof, pri_eof};
  assign ln_ok      = {sby_ok,  pri_ok};
  assign ln_word[0] = pri_word;
  assign ln_word[1] = sby_word;

  for (genvar l = 0; l < 2; l++) begin : g_line
    sfr_line_capture #(.WORD_W(WORD_W), .DEPTH(PORT_WORDS)) u_cap (
      .clk    (clk),
      .rst    (rst),
      .clr    (clr_q),
      .in_vld (ln_vld[l]),
      .in_word(ln_word[l]),
      .in_mst (ln_mst[l]),
      .in_eof (ln_eof[l]),
      .in_ok  (ln_ok[l]),
      .done   (cap_done[l]),
      .good   (cap_good[l]),
      .is_mst (cap_mst[l]),
      .nwords (cap_n[l]),
      .words  (cap_buf[l])
    );
  end

  // ---------------- copy selection
  logic              use_pri, use_sby, any_good, csel;
  logic [WORD_W-1:0] w0;
  logic [FC_W-1:0]   fcode;
  logic [ADDR_W-1:0] maddr;
  logic              mst_ok;
  logic [CNT_W-1:0]  fc_len;

  assign use_pri  = cap_done[0] && cap_good[0];
  assign use_sby  = !use_pri && cap_done[1] && cap_good[1];
  assign any_good = use_pri || use_sby;
  assign csel     = use_sby;
  assign w0       = cap_buf[csel][WORD_W-1:0];
  assign fcode    = w0[WORD_W-1 -: FC_W];
  assign maddr    = w0[ADDR_W-1:0];
  assign mst_ok   = cap_mst[csel] && (cap_n[csel] == CNT_W'(1));
  assign fc_len   = CNT_W'(1) << fcode;

  logic              pm_hit, pm_src, pm_snk, pm_dv;
  logic [PIDX_W-1:0] pm_idx;

  sfr_port_match #(.NPORT(NPORT), .ADDR_W(ADDR_W)) u_match (
    .addr   (maddr),
    .cfg_la (cfg_la),
    .cfg_src(cfg_src),
    .cfg_snk(cfg_snk),
    .cfg_dv (cfg_dv),
    .hit    (pm_hit),
    .idx    (pm_idx),
    .is_src (pm_src),
    .is_snk (pm_snk),
    .dvalid (pm_dv)
  );

  logic pd_req;
  assign pd_req = (fcode <= FC_W'(MAX_FC)) && pm_hit;

  // ---------------- control
  sfr_state_e        state;
  logic [SKW_W-1:0]  skew;
  logic              sel_q;
  logic [CNT_W-1:0]  cnt, len;
  logic [PIDX_W-1:0] port_q;
  sfr_src_e          kind;
  logic              arm_v;
  logic [PIDX_W-1:0] arm_port;
  logic [CNT_W-1:0]  arm_len;
  logic              p1_v, p1_f, p1_l, p2_v, p2_f, p2_l;
  sfr_src_e          p1_k, p2_k;
  logic [WORD_W-1:0] wr_word;
  logic              at_end;

  assign wr_word = cap_buf[sel_q][cnt[OFF_W-1:0]*WORD_W +: WORD_W];
  assign at_end  = (cnt == len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_WAIT;
      skew      <= '0;
      sel_q     <= 1'b0;
      cnt       <= '0;
      len       <= '0;
      port_q    <= '0;
      kind      <= SRC_RAM;
      arm_v     <= 1'b0;
      arm_port  <= '0;
      arm_len   <= '0;
      clr_q     <= 1'b0;
      ram_en    <= 1'b0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      p1_v      <= 1'b0;
      p1_f      <= 1'b0;
      p1_l      <= 1'b0;
      p1_k      <= SRC_RAM;
    end else begin
      clr_q  <= 1'b0;
      ram_en <= 1'b0;
      ram_we <= 1'b0;
      p1_v   <= 1'b0;
      p1_f   <= 1'b0;
      p1_l   <= 1'b0;
      unique case (state)
        ST_WAIT: begin
          if ((|cap_done) && !clr_q) begin
            skew  <= '0;
            state <= ST_RECV;
          end
        end
        ST_RECV: begin
          if ((&cap_done) || skew == SKW_W'(SKEW_MAX)) state <= ST_CHECK;
          else skew <= skew + 1'b1;
        end
        ST_CHECK: begin
          cnt   <= '0;
          sel_q <= csel;
          state <= ST_WAIT;
          clr_q <= 1'b1;
          if (any_good && mst_ok) begin
            arm_v <= 1'b0;
            if (pd_req && pm_src) begin
              port_q <= pm_idx;
              len    <= fc_len;
              kind   <= pm_dv ? SRC_RAM : SRC_ZERO;
              state  <= ST_READ;
              clr_q  <= 1'b0;
            end else if (pd_req && pm_snk) begin
              arm_v    <= 1'b1;
              arm_port <= pm_idx;
              arm_len  <= fc_len;
            end else if (fcode == FC_STATUS && maddr == dev_addr) begin
              len   <= CNT_W'(1);
              kind  <= SRC_STAT;
              state <= ST_READ;
              clr_q <= 1'b0;
            end
          end else if (any_good && !cap_mst[csel]) begin
            arm_v <= 1'b0;
            if (arm_v && cap_n[csel] == arm_len) begin
              port_q <= arm_port;
              len    <= arm_len;
              state  <= ST_WRITE;
              clr_q  <= 1'b0;
            end
          end
        end
        ST_WRITE: begin
          ram_en    <= 1'b1;
          ram_we    <= 1'b1;
          ram_addr  <= {port_q, cnt[OFF_W-1:0]};
          ram_wdata <= wr_word;
          cnt       <= cnt + 1'b1;
          if (at_end) begin
            state <= ST_WAIT;
            clr_q <= 1'b1;
          end
        end
        ST_READ: begin
          p1_v <= 1'b1;
          p1_f <= (cnt == '0);
          p1_l <= at_end;
          p1_k <= kind;
          if (kind == SRC_RAM) begin
            ram_en   <= 1'b1;
            ram_addr <= {port_q, cnt[OFF_W-1:0]};
          end
          cnt <= cnt + 1'b1;
          if (at_end) state <= ST_DRAIN;
        end
        ST_DRAIN: begin
          if (!p1_v && !p2_v) begin
            state <= ST_WAIT;
            clr_q <= 1'b1;
          end
        end
        default: state <= ST_WAIT;
      endcase
    end
  end

  // ---------------- reply pipeline: RAM read latency then output register
  always_ff @(posedge clk) begin
    if (rst) begin
      p2_v     <= 1'b0;
      p2_f     <= 1'b0;
      p2_l     <= 1'b0;
      p2_k     <= SRC_RAM;
      tx_valid <= 1'b0;
      tx_first <= 1'b0;
      tx_last  <= 1'b0;
      tx_data  <= '0;
    end else begin
      p2_v     <= p1_v;
      p2_f     <= p1_f;
      p2_l     <= p1_l;
      p2_k     <= p1_k;
      tx_valid <= p2_v;
      tx_first <= p2_v && p2_f;
      tx_last  <= p2_v && p2_l;
      if (!p2_v) tx_data <= '0;
      else begin
        unique case (p2_k)
          SRC_RAM:  tx_data <= ram_rdata;
          SRC_STAT: tx_data <= dev_status;
          default:  tx_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sfr_responder_chk.sv
module sfr_responder_chk #(
  parameter int RAM_AW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tx_valid,
  input logic              tx_first,
  input logic              tx_last,
  input logic              ram_en,
  input logic              ram_we,
  input logic [RAM_AW-1:0] ram_addr
);
  // R11: framing marks only on valid words
  a_r11_first_valid: assert property (@(posedge clk) disable iff (rst)
    tx_first |-> tx_valid);
  a_r11_last_valid: assert property (@(posedge clk) disable iff (rst)
    tx_last |-> tx_valid);
  // R11: no gap inside a reply
  a_r11_no_gap: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_last) |=> tx_valid);
  // R11: a reply opens with its first word
  a_r11_opens_first: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_valid) |-> tx_first);
  // R8: writes are enabled accesses at rising addresses
  a_r8_we_en: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> ram_en);
  a_r8_seq_addr: assert property (@(posedge clk) disable iff (rst)
    (ram_we && $past(ram_we)) |-> ram_addr == $past(ram_addr) + 1'b1);
  // R4: storing and replying never overlap
  a_r4_write_no_tx: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !tx_valid);
endmodule

bind sfr_responder sfr_responder_chk #(.RAM_AW(RAM_AW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tx_valid(tx_valid),
  .tx_first(tx_first),
  .tx_last (tx_last),
  .ram_en  (ram_en),
  .ram_we  (ram_we),
  .ram_addr(ram_addr)
);

// File: tb/test_sfr_responder.sv
`timescale 1ns/1ps
module test_sfr_responder;
  localparam int WW = 16;
  localparam int AW = 12;
  localparam int NP = 16;
  localparam int RAW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          pri_vld = 0, pri_mst = 0, pri_eof = 0, pri_ok = 0;
  logic          sby_vld = 0, sby_mst = 0, sby_eof = 0, sby_ok = 0;
  logic [WW-1:0] pri_word = '0, sby_word = '0;
  logic [AW-1:0] dev_addr = 12'h7A5;
  logic [WW-1:0] dev_status = 16'hC3C3;
  logic [NP*AW-1:0] cfg_la = '0;
  logic [NP-1:0] cfg_src = '0, cfg_snk = '0, cfg_dv = '0;
  logic          ram_en, ram_we;
  logic [RAW-1:0] ram_addr;
  logic [WW-1:0] ram_wdata;
  logic [WW-1:0] ram_rdata = '0;
  logic          tx_valid, tx_first, tx_last;
  logic [WW-1:0] tx_data;

  sfr_responder i_sfr_responder (
    .clk(clk), .rst(rst),
    .pri_vld(pri_vld), .pri_word(pri_word), .pri_mst(pri_mst), .pri_eof(pri_eof), .pri_ok(pri_ok),
    .sby_vld(sby_vld), .sby_word(sby_word), .sby_mst(sby_mst), .sby_eof(sby_eof), .sby_ok(sby_ok),
    .dev_addr(dev_addr), .dev_status(dev_status),
    .cfg_la(cfg_la), .cfg_src(cfg_src), .cfg_snk(cfg_snk), .cfg_dv(cfg_dv),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .tx_valid(tx_valid), .tx_first(tx_first), .tx_last(tx_last), .tx_data(tx_data)
  );

  // shared port RAM model, one-cycle read
  logic [WW-1:0] mem [256];
  function automatic logic [WW-1:0] init_val(int a);
    return 16'h8000 | 16'((a / 16) << 8) | 16'(a % 16);
  endfunction
  initial for (int a = 0; a < 256; a++) mem[a] = init_val(a);
  always @(posedge clk) begin
    if (ram_en) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      else        ram_rdata <= mem[ram_addr];
    end
  end

  // reply collector, sampled on the falling edge
  logic [WW-1:0] got [32];
  int ngot = 0, nfirst = 0, fpos = -1, lpos = -1, writes = 0;
  always @(negedge clk) begin
    if (!rst && tx_valid && ngot < 32) begin
      got[ngot] = tx_data;
      if (tx_first) begin nfirst++; fpos = ngot; end
      if (tx_last) lpos = ngot;
      ngot++;
    end
    if (!rst && ram_en && ram_we) writes++;
  end

  int checks = 0, errors = 0;
  bit finished = 0;
  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_rx();
    ngot = 0; nfirst = 0; fpos = -1; lpos = -1;
  endtask

  logic [WW-1:0] fa [16];
  logic [WW-1:0] fb [16];

  task automatic drive(input int ln, input bit mst, input int n, input bit ok, input int dly);
    repeat (dly) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (ln == 0) begin
        pri_vld = 1; pri_word = fa[k]; pri_mst = mst; pri_eof = (k == n - 1); pri_ok = ok;
      end else begin
        sby_vld = 1; sby_word = fb[k]; sby_mst = mst; sby_eof = (k == n - 1); sby_ok = ok;
      end
    end
    @(negedge clk);
    if (ln == 0) begin pri_vld = 0; pri_eof = 0; end
    else begin sby_vld = 0; sby_eof = 0; end
  endtask

  task automatic xfer(input bit mst, input int na, input bit oka, input int nb, input bit okb, input int dlyb);
    clear_rx();
    fork
      begin if (na > 0) drive(0, mst, na, oka, 0); end
      begin if (nb > 0) drive(1, mst, nb, okb, dlyb); end
    join
    repeat (60) @(negedge clk);
  endtask

  task automatic master(input int fc, input int addr_a, input int addr_b,
                        input bit oka, input bit okb, input int dlyb, input bit sby_on);
    fa[0] = {4'(fc), 12'(addr_a)};
    fb[0] = {4'(fc), 12'(addr_b)};
    xfer(1'b1, 1, oka, sby_on ? 1 : 0, okb, dlyb);
  endtask

  // mode 0 RAM of port, 1 zeros, 2 status word
  task automatic expect_reply(input string req, input int n, input int port, input int mode);
    chk(req, ngot, n);
    chk(req, nfirst, 1);
    chk(req, fpos, 0);
    chk(req, lpos, n - 1);
    for (int k = 0; k < n && k < ngot; k++) begin
      if (mode == 0)      chk(req, got[k], init_val(port * 16 + k));
      else if (mode == 1) chk(req, got[k], 0);
      else                chk(req, got[k], dev_status);
    end
  endtask

  task automatic t_reset();
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 ram_en", ram_en, 0);
    chk("R1 no reply", ngot, 0);
  endtask

  task automatic t_lengths();
    master(2, 12'h101, 12'h101, 1, 1, 0, 1);
    expect_reply("R2 R11 fc2", 4, 0, 0);
    master(4, 12'h101, 12'h101, 1, 1, 0, 1);
    expect_reply("R2 R11 fc4", 16, 0, 0);
    master(0, 12'h101, 12'h101, 1, 1, 0, 1);
    expect_reply("R2 fc0", 1, 0, 0);
  endtask

  task automatic t_duplicate();
    master(1, 12'h101, 12'h101, 1, 1, 0, 1);
    expect_reply("R9 lowest entry", 2, 0, 0);
  endtask

  task automatic t_copy_choice();
    master(1, 12'h404, 12'h101, 0, 1, 0, 1);
    expect_reply("R3 standby fallback", 2, 0, 0);
    master(0, 12'h101, 12'h303, 1, 1, 0, 1);
    expect_reply("R3 primary preferred", 1, 0, 0);
  endtask

  task automatic t_both_bad();
    int w0 = writes;
    master(1, 12'h101, 12'h101, 0, 0, 0, 1);
    chk("R4 no reply", ngot, 0);
    chk("R4 no write", writes - w0, 0);
  endtask

  task automatic t_skew();
    master(1, 12'h101, 12'h101, 0, 1, 5, 1);
    expect_reply("R10 late standby", 2, 0, 0);
    master(0, 12'h101, 12'h101, 1, 0, 0, 0);
    expect_reply("R10 primary only", 1, 0, 0);
  endtask

  task automatic t_invalid();
    master(1, 12'h202, 12'h202, 1, 1, 0, 1);
    expect_reply("R6 zero data", 2, 1, 1);
  endtask

  task automatic t_unconf();
    master(0, 12'h404, 12'h404, 1, 1, 0, 1);
    chk("R5 unconfigured entry", ngot, 0);
    master(3, 12'h555, 12'h555, 1, 1, 0, 1);
    chk("R5 unknown address", ngot, 0);
  endtask

  task automatic t_status();
    master(15, 12'h7A5, 12'h7A5, 1, 1, 0, 1);
    expect_reply("R7 status", 1, 0, 2);
    master(15, 12'h101, 12'h101, 1, 1, 0, 1);
    chk("R7 other address", ngot, 0);
  endtask

  task automatic t_other_fc();
    int w0 = writes;
    master(7, 12'h101, 12'h101, 1, 1, 0, 1);
    chk("R12 no reply", ngot, 0);
    master(6, 12'h303, 12'h303, 1, 1, 0, 1);
    fa[0] = 16'h1234; fb[0] = 16'h1234;
    xfer(1'b0, 1, 1, 1, 1, 0);
    chk("R12 no write", writes - w0, 0);
  endtask

  task automatic t_sink();
    int w0;
    master(1, 12'h303, 12'h303, 1, 1, 0, 1);
    chk("R8 no reply to sink", ngot, 0);
    fa[0] = 16'hDEAD; fa[1] = 16'hBEEF; fb[0] = 16'hDEAD; fb[1] = 16'hBEEF;
    w0 = writes;
    xfer(1'b0, 2, 1, 2, 1, 0);
    chk("R8 write count", writes - w0, 2);
    chk("R8 word 0", mem[32], 16'hDEAD);
    chk("R8 word 1", mem[33], 16'hBEEF);
    master(1, 12'h303, 12'h303, 1, 1, 0, 1);
    fa[0] = 16'h1111; fa[1] = 16'h2222; fa[2] = 16'h3333;
    fb[0] = 16'h1111; fb[1] = 16'h2222; fb[2] = 16'h3333;
    w0 = writes;
    xfer(1'b0, 3, 1, 3, 1, 0);
    chk("R8 length mismatch", writes - w0, 0);
    chk("R8 kept word", mem[32], 16'hDEAD);
    fa[0] = 16'h4444; fa[1] = 16'h5555; fb[0] = 16'h4444; fb[1] = 16'h5555;
    xfer(1'b0, 2, 1, 2, 1, 0);
    chk("R8 unrequested frame", writes - w0, 0);
    chk("R8 kept word 1", mem[33], 16'hBEEF);
  endtask

  initial begin
    // entry 0 source, 1 source with invalid data, 2 sink, 3 duplicate of 0, 4 unconfigured
    cfg_la[0*AW +: AW] = 12'h101; cfg_src[0] = 1; cfg_dv[0] = 1;
    cfg_la[1*AW +: AW] = 12'h202; cfg_src[1] = 1; cfg_dv[1] = 0;
    cfg_la[2*AW +: AW] = 12'h303; cfg_snk[2] = 1;
    cfg_la[3*AW +: AW] = 12'h101; cfg_src[3] = 1; cfg_dv[3] = 1;
    cfg_la[4*AW +: AW] = 12'h404;
    repeat (5) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_lengths();
    t_duplicate();
    t_copy_choice();
    t_both_bad();
    t_skew();
    t_invalid();
    t_unconf();
    t_status();
    t_other_fc();
    t_sink();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule